// File: doc/BRIEF.md
# Interleaved Dual-Bank Burst Read Sequencer

This block is the read path for word storage that is split into two banks. One bank holds the even word addresses and the other holds the odd ones. Each bank has its own address counter. A random access starts when the host latches a word address. After that, each rising edge on the read strobe presents the next word in linear order. The words come from the two banks in turn, and the burst has no length limit.

The counter of the bank that was just read steps by one, so it is ready for that bank's next turn. On an odd start address the even counter is loaded one word ahead. Raising chip select puts the block into standby and freezes all sequencing state. Lowering chip select again, without a new latch, continues the burst from the point where it stopped. Both banks are synthesizable arrays, and a preload write port fills them. With the default parameter each bank holds 256 words; setting `BANK_AW` to 15 gives two banks of 32K words.

Top module: `ilv_burst_reader`

## Requirements
- R1: A preload write with `ld_we` high stores `ld_data` at word address `ld_addr`. Bit 0 of `ld_addr` selects the bank (0 = even, 1 = odd), and bits `[BANK_AW:1]` give the location inside that bank.
- R2: A random-access start is `ale` high while `cs_n` is low at a rising clock edge. The word at the latched address `addr` appears on `dout` at the second rising edge after the start edge.
- R3: On a start with `addr[0]` = 0, both bank counters load `addr[BANK_AW:1]`, and the first word comes from the even bank.
- R4: On a start with `addr[0]` = 1, the odd counter loads `addr[BANK_AW:1]`, the even counter loads that value plus one, and the first word comes from the odd bank.
- R5: A rising edge of `rd` with `cs_n` low and `ale` low is one sequential step. The bank select toggles, only the counter of the bank just read increments, and `dout` shows the next linear word two edges later.
- R6: `rd` held high for several clocks causes exactly one step.
- R7: While `cs_n` is high, `oe` is low from the next edge on. The counters and the bank select hold their values, and edges on `rd` are ignored.
- R8: Lowering `cs_n` with `ale` low after standby resumes the burst with the next word after the last one presented, and nothing is reloaded.
- R9: After the last word address (all ones), the stream continues at word address 0. This holds for an even start and for an odd start.
- R10: When a start and a rising `rd` edge happen at the same edge, the start wins, and the first word is the one at the latched address.
- R11: While synchronous reset `rst` is high, both counters and the bank select clear to zero (even bank next), and `oe` and `dout` are zero at the first edge in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address latch enable, starts a random access |
| cs_n | input | 1 | Active-low chip select; high means standby |
| rd | input | 1 | Read strobe; each rising edge is one sequential step |
| addr | input | BANK_AW+1 | Word address latched on a start |
| ld_we | input | 1 | Preload write enable |
| ld_addr | input | BANK_AW+1 | Preload word address |
| ld_data | input | 16 | Preload data word |
| dout | output | 16 | Registered data word |
| oe | output | 1 | Output enable; low models high impedance |

## Verification
Bursts are started at even and at odd addresses. Comparing the two shows whether the even counter's +1 preload and the first-bank choice are right. Starts just below the top address show the wrap in both counters. Standby gaps with strobe toggling inside them separate a true resume from a reload or a missed freeze. A start that coincides with a strobe edge, and a strobe held high across several clocks, check the priority and the edge detection. Random bursts with random lengths and random standby breaks are compared against a linear reference pointer.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic {BANK_EVEN = 1'b0, BANK_ODD = 1'b1} bank_e;
endpackage

// File: rtl/ilv_bank_ram.sv
module ilv_bank_ram
  import ilv_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  localparam int DEPTH = 1 << AW;

  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ilv_bank_ctr.sv
module ilv_bank_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ilv_burst_reader.sv
module ilv_burst_reader
  import ilv_pkg::*;
#(
  parameter int BANK_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ale,
  input  logic               cs_n,
  input  logic               rd,
  input  logic [BANK_AW:0]   addr,
  input  logic               ld_we,
  input  logic [BANK_AW:0]   ld_addr,
  input  logic [15:0]        ld_data,
  output logic [15:0]        dout,
  output logic               oe
);
  localparam int NBANK = 2;

  logic               rd_q;
  logic               rd_rise;
  logic               start;
  logic               step;
  bank_e              sel;
  bank_e              sel_q;
  logic [BANK_AW-1:0] idx;
  logic [BANK_AW-1:0] cnt  [NBANK];
  logic [BANK_AW-1:0] ldv  [NBANK];
  word_t              q    [NBANK];

  assign idx     = addr[BANK_AW:1];
  assign rd_rise = rd & ~rd_q;
  assign start   = ale & ~cs_n;
  assign step    = ~cs_n & ~ale & rd_rise;

  // Even counter runs one word ahead on an odd start.
  assign ldv[0] = idx + {{(BANK_AW-1){1'b0}}, addr[0]};
  assign ldv[1] = idx;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd;
  end

  always_ff @(posedge clk) begin
    if (rst)        sel <= BANK_EVEN;
    else if (start) sel <= bank_e'(addr[0]);
    else if (step)  sel <= (sel == BANK_EVEN) ? BANK_ODD : BANK_EVEN;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic inc_b;
    logic we_b;
    assign inc_b = step & (sel == bank_e'(b));
    assign we_b  = ld_we & (ld_addr[0] == 1'(b));

    ilv_bank_ctr #(.AW(BANK_AW)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (start),
      .load_val (ldv[b]),
      .inc      (inc_b),
      .cnt      (cnt[b])
    );

    ilv_bank_ram #(.AW(BANK_AW)) u_ram (
      .clk   (clk),
      .we    (we_b),
      .waddr (ld_addr[BANK_AW:1]),
      .wdata (ld_data),
      .raddr (cnt[b]),
      .rdata (q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= BANK_EVEN;
      dout  <= '0;
      oe    <= 1'b0;
    end else begin
      sel_q <= sel;
      dout  <= q[sel_q];
      oe    <= ~cs_n;
    end
  end
endmodule

// File: rtl/ilv_burst_reader_sva.sv
module ilv_burst_reader_sva #(
  parameter int BANK_AW = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               ale,
  input logic               cs_n,
  input logic               rd,
  input logic [BANK_AW:0]   addr,
  input logic               oe,
  input logic [BANK_AW-1:0] even_cnt,
  input logic [BANK_AW-1:0] odd_cnt,
  input logic               sel
);
  // R7
  a_r7_oe_off: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !oe);

  // R7
  a_r7_standby_hold: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(even_cnt) && $stable(odd_cnt) && $stable(sel)));

  // R3
  a_r3_even_start: assert property (@(posedge clk) disable iff (rst)
    (ale && !cs_n && !addr[0]) |=> (even_cnt == odd_cnt) && !sel);

  // R4
  a_r4_odd_start: assert property (@(posedge clk) disable iff (rst)
    (ale && !cs_n && addr[0]) |=> (even_cnt == odd_cnt + 1'b1) && sel);

  // R5
  a_r5_toggle: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ale && $rose(rd)) |=> (sel != $past(sel)));

  // R5
  a_r5_one_ctr: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ale && $rose(rd)) |=>
      ($countones({even_cnt != $past(even_cnt), odd_cnt != $past(odd_cnt)}) == 1));

  // R6
  a_r6_held_rd: assert property (@(posedge clk) disable iff (rst)
    (!ale && rd && $past(rd)) |=> $stable(sel));
endmodule

bind ilv_burst_reader ilv_burst_reader_sva #(.BANK_AW(BANK_AW)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .ale      (ale),
  .cs_n     (cs_n),
  .rd       (rd),
  .addr     (addr),
  .oe       (oe),
  .even_cnt (cnt[0]),
  .odd_cnt  (cnt[1]),
  .sel      (sel)
);

// File: tb/ilv_burst_reader_test.sv
module ilv_burst_reader_test;
  localparam int AW    = 8;
  localparam int WORDS = 1 << (AW + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          ale, cs_n, rd, ld_we;
  logic [AW:0]   addr, ld_addr, ptr;
  logic [15:0]   ld_data, dout;
  logic          oe;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  ilv_burst_reader #(.BANK_AW(AW)) uut (
    .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd(rd), .addr(addr),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data), .dout(dout), .oe(oe)
  );

  function automatic logic [15:0] pat(input logic [AW:0] a);
    logic [15:0] w;
    w = 16'(a);
    return (w * 16'h9E37) ^ 16'h5A5A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start_at(input logic [AW:0] a, input string req);
    addr = a; ale = 1'b1; cs_n = 1'b0;
    ticks(1);
    ale = 1'b0;
    ptr = a;
    ticks(3);
    chk(req, {16'h0, dout}, {16'h0, pat(ptr)});
  endtask

  task automatic step(input string req);
    rd = 1'b1; ticks(1);
    rd = 1'b0; ticks(3);
    ptr = ptr + 1'b1;
    chk(req, {16'h0, dout}, {16'h0, pat(ptr)});
  endtask

  task automatic standby(input int n, input string req);
    cs_n = 1'b1;
    ticks(2);
    chk(req, {31'h0, oe}, 32'h0);
    for (int i = 0; i < n; i++) begin
      rd = 1'b1; ticks(1); rd = 1'b0; ticks(1);
    end
    cs_n = 1'b0;
    ticks(3);
    chk("R8 resume", {16'h0, dout}, {16'h0, pat(ptr)});
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; ale = 1'b0; cs_n = 1'b1; rd = 1'b0;
    addr = '0; ld_we = 1'b0; ld_addr = '0; ld_data = '0; ptr = '0;
    ticks(3);
    chk("R11 oe in reset", {31'h0, oe}, 32'h0);
    chk("R11 dout in reset", {16'h0, dout}, 32'h0);
    rst = 1'b0;
    // R1 preload all words
    for (int a = 0; a < WORDS; a++) begin
      ld_we = 1'b1; ld_addr = (AW+1)'(a); ld_data = pat((AW+1)'(a));
      ticks(1);
    end
    ld_we = 1'b0;
    // R11 after reset, counters at 0 and even bank first
    cs_n = 1'b0;
    ticks(3);
    chk("R11 reset counters", {16'h0, dout}, {16'h0, pat('0)});
    chk("R1 oe on", {31'h0, oe}, 32'h1);
    // R3 even start
    start_at(9'd0, "R2 R3 even start");
    for (int i = 0; i < 5; i++) step("R5 even burst");
    // R4 odd start
    start_at(9'd5, "R2 R4 odd start");
    for (int i = 0; i < 5; i++) step("R5 odd burst");
    // R9 wrap from odd and even starts
    start_at(9'd511, "R9 odd last");
    step("R9 odd wrap"); step("R9 after wrap");
    start_at(9'd510, "R9 even near last");
    step("R9 last"); step("R9 even wrap");
    // R6 held strobe
    rd = 1'b1; ticks(5); rd = 1'b0; ticks(3);
    ptr = ptr + 1'b1;
    chk("R6 held rd single step", {16'h0, dout}, {16'h0, pat(ptr)});
    // R7 R8 standby with ignored strobes
    start_at(9'd33, "R4 start before standby");
    step("R5 pre standby");
    standby(3, "R7 oe low");
    step("R8 step after resume");
    // R10 start and strobe edge together
    addr = 9'd200; ale = 1'b1; rd = 1'b1;
    ticks(1);
    ale = 1'b0; rd = 1'b0; ptr = 9'd200;
    ticks(3);
    chk("R10 start wins", {16'h0, dout}, {16'h0, pat(ptr)});
    step("R10 first step after");
    // random bursts
    for (int k = 0; k < 25; k++) begin
      start_at((AW+1)'($urandom), "R2 random start");
      for (int s = 0; s < int'($urandom_range(1, 8)); s++) begin
        if ($urandom_range(0, 4) == 0) standby(int'($urandom_range(0, 2)), "R7 random standby");
        step("R5 random step");
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule